// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This block sits after the adder/subtracter of a fixed-point datapath that keeps two 40-bit signed accumulators in 9.31 fractional form. A 1.31 value fills the lower 32 bits, and the eight bits above bit 31 act as guard bits. On each valid strobe the block adds or subtracts two 40-bit operands. It then decides the value written into the selected accumulator, and that decision depends on one of three overflow policies. Full-width saturation clamps at the 40-bit limits. Narrow saturation clamps at the 1.31 limits and ignores the guard bits. Wrap mode applies no clamp and lets the sum overflow.

For each accumulator the block keeps a guard-overflow flag and a sticky saturation flag. It also drives two combined flags, which OR the per-accumulator flags together, and a trap request that marks a destructive wrap when trapping is enabled. Instruction decode, the multiplier and the trap handler sit outside this block. Those parts drive the strobe and the mode pins and consume the flags.

Top module: `dual_acc_sat`

## Requirements
- R1: After a synchronous reset, both accumulators, all four per-accumulator flags, both combined flags and the trap request read zero.
- R2: When add_vld is high, the selected accumulator (acc_sel 0 or 1) takes op_a+op_b, or op_a-op_b when op_sub is 1, at the next clock edge. The other accumulator does not change. With add_vld low, neither accumulator changes.
- R3: Full saturation (sat_en=1, sat_at_31=0) applies when the 41-bit signed sum leaves the 40-bit range. A positive overflow loads 0x7FFFFFFFFF and a negative one loads 0x8000000000, and the selected saturation flag is set.
- R4: Narrow saturation (sat_en=1, sat_at_31=1) applies when the sum falls outside [-2^31, 2^31-1]. A positive overflow loads 0x007FFFFFFF and a negative one loads 0xFF80000000, and the saturation flag is set. A sum that lands exactly on a limit is written unchanged and sets no flag.
- R5: After a write in narrow mode, the guard-overflow flag of the written accumulator is 0.
- R6: Wrap mode (sat_en=0, sat_at_31 ignored) writes the low 40 bits of the sum. A bit-39 overflow, where the two top bits of the 41-bit sum differ, sets the saturation flag.
- R7: After a write in full or wrap mode, the guard-overflow flag of that accumulator is 1 exactly when bits 39 down to 31 of the written value are not all equal. The flag keeps its value until the next write to that accumulator.
- R8: A saturation flag is sticky. Only its own bit of clr_sat clears it. When a set and a clear fall in the same cycle, the set wins. A clear aimed at one accumulator leaves the other flag untouched.
- R9: trap_req is high for the one cycle after a write in wrap mode with trap_en=1 that overflows bit 39. In every other case trap_req is 0.
- R10: ovf_any equals the OR of both guard-overflow flags, and sat_any equals the OR of both saturation flags, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_vld | input | 1 | Operation strobe |
| acc_sel | input | 1 | Target accumulator |
| op_sub | input | 1 | 1 selects op_a minus op_b |
| op_a | input | ACC_W (40) | First signed operand |
| op_b | input | ACC_W (40) | Second signed operand |
| sat_en | input | 1 | Saturation enable |
| sat_at_31 | input | 1 | 1 selects narrow (1.31) saturation |
| trap_en | input | 1 | Allows a trap request on a wrap overflow |
| clr_sat | input | 2 | Per-accumulator saturation flag clear |
| acc0 | output | ACC_W (40) | Accumulator 0 |
| acc1 | output | ACC_W (40) | Accumulator 1 |
| ovf_flag | output | 2 | Guard-overflow flags |
| sat_flag | output | 2 | Sticky saturation flags |
| ovf_any | output | 1 | OR of guard-overflow flags |
| sat_any | output | 1 | OR of saturation flags |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions assume that reset is held for at least one edge before any strobe. They also assume that the mode pins, the operands and clr_sat are stable around each edge, because all of them are sampled only at the edge that accepts add_vld. The bench meets both assumptions by driving every input at the falling edge and by holding reset through two edges at start-up. The sweep runs a small 10-bit configuration with three guard bits. Every pattern of op_a meets a fixed set of op_b values that sit on and next to both clamp limits, and this happens in all three modes, so every mode, sign and clamp boundary is reached with legal stimulus.

// File: rtl/dsat_pkg.sv
package dsat_pkg;

  typedef enum logic [1:0] {
    SM_WRAP   = 2'd0,
    SM_FULL   = 2'd1,
    SM_NARROW = 2'd2
  } sat_mode_e;

  function automatic sat_mode_e pick_mode(input logic en, input logic at31);
    if (!en)      return SM_WRAP;
    else if (at31) return SM_NARROW;
    else          return SM_FULL;
  endfunction

endpackage

// File: rtl/dsat_addsub.sv
module dsat_addsub #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] a_in,
  input  logic [ACC_W-1:0] b_in,
  input  logic             sub,
  output logic [ACC_W:0]   sum
);
  logic [ACC_W:0] ext_a;
  logic [ACC_W:0] ext_b;

  always_comb begin
    ext_a = {a_in[ACC_W-1], a_in};
    ext_b = {b_in[ACC_W-1], b_in};
    sum   = sub ? (ext_a - ext_b) : (ext_a + ext_b);
  end
endmodule

// File: rtl/dsat_limiter.sv
module dsat_limiter
  import dsat_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 31
) (
  input  logic [ACC_W:0]   sum,
  input  sat_mode_e        mode,
  output logic [ACC_W-1:0] result,
  output logic             sat_hit,
  output logic             guard_ovf,
  output logic             wrap_ovf
);
  localparam int TOP_W = ACC_W - FRAC_W;
  localparam logic [ACC_W-1:0] FULL_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FULL_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] NAR_MAX  = {{TOP_W{1'b0}}, {FRAC_W{1'b1}}};
  localparam logic [ACC_W-1:0] NAR_MIN  = {{TOP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic wide_ovf;
  logic narrow_ovf;
  logic [TOP_W:0]   sum_top;
  logic [TOP_W-1:0] res_top;

  always_comb begin
    sum_top    = sum[ACC_W:FRAC_W];
    wide_ovf   = sum[ACC_W] ^ sum[ACC_W-1];
    narrow_ovf = !((&sum_top) || !(|sum_top));

    result  = sum[ACC_W-1:0];
    sat_hit = 1'b0;
    unique case (mode)
      SM_FULL: begin
        sat_hit = wide_ovf;
        if (wide_ovf) result = sum[ACC_W] ? FULL_MIN : FULL_MAX;
      end
      SM_NARROW: begin
        sat_hit = narrow_ovf;
        if (narrow_ovf) result = sum[ACC_W] ? NAR_MIN : NAR_MAX;
      end
      default: begin
        sat_hit = wide_ovf;
      end
    endcase

    res_top   = result[ACC_W-1:FRAC_W];
    guard_ovf = (mode != SM_NARROW) && !((&res_top) || !(|res_top));
    wrap_ovf  = (mode == SM_WRAP) && wide_ovf;
  end
endmodule

// File: rtl/dsat_acc_bank.sv
module dsat_acc_bank #(
  parameter int ACC_W = 40,
  parameter int N_ACC = 2,
  localparam int SEL_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [ACC_W-1:0]            wr_data,
  input  logic                        wr_ovf,
  input  logic                        wr_sat,
  input  logic [N_ACC-1:0]            clr,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_q,
  output logic [N_ACC-1:0]            ovf_q,
  output logic [N_ACC-1:0]            sat_q,
  output logic                        ovf_any_q,
  output logic                        sat_any_q
);
  logic [N_ACC-1:0]            hit;
  logic [N_ACC-1:0][ACC_W-1:0] acc_nxt;
  logic [N_ACC-1:0]            ovf_nxt;
  logic [N_ACC-1:0]            sat_nxt;

  for (genvar g = 0; g < N_ACC; g++) begin : g_slot
    assign hit[g]     = wr_en && (wr_sel == SEL_W'(g));
    assign acc_nxt[g] = hit[g] ? wr_data : acc_q[g];
    assign ovf_nxt[g] = hit[g] ? wr_ovf : ovf_q[g];
    assign sat_nxt[g] = (hit[g] && wr_sat) || (sat_q[g] && !clr[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ovf_q     <= '0;
      sat_q     <= '0;
      ovf_any_q <= 1'b0;
      sat_any_q <= 1'b0;
    end else begin
      acc_q     <= acc_nxt;
      ovf_q     <= ovf_nxt;
      sat_q     <= sat_nxt;
      ovf_any_q <= |ovf_nxt;
      sat_any_q <= |sat_nxt;
    end
  end
endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat
  import dsat_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  localparam int FRAC_W = ACC_W - GUARD_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_vld,
  input  logic             acc_sel,
  input  logic             op_sub,
  input  logic [ACC_W-1:0] op_a,
  input  logic [ACC_W-1:0] op_b,
  input  logic             sat_en,
  input  logic             sat_at_31,
  input  logic             trap_en,
  input  logic [1:0]       clr_sat,
  output logic [ACC_W-1:0] acc0,
  output logic [ACC_W-1:0] acc1,
  output logic [1:0]       ovf_flag,
  output logic [1:0]       sat_flag,
  output logic             ovf_any,
  output logic             sat_any,
  output logic             trap_req
);
  localparam int N_ACC = 2;

  sat_mode_e               mode;
  logic [ACC_W:0]          sum;
  logic [ACC_W-1:0]        result;
  logic                    sat_hit;
  logic                    guard_ovf;
  logic                    wrap_ovf;
  logic [N_ACC-1:0][ACC_W-1:0] acc_q;

  assign mode = pick_mode(sat_en, sat_at_31);

  dsat_addsub #(.ACC_W(ACC_W)) u_add (
    .a_in (op_a),
    .b_in (op_b),
    .sub  (op_sub),
    .sum  (sum)
  );

  dsat_limiter #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_lim (
    .sum       (sum),
    .mode      (mode),
    .result    (result),
    .sat_hit   (sat_hit),
    .guard_ovf (guard_ovf),
    .wrap_ovf  (wrap_ovf)
  );

  dsat_acc_bank #(.ACC_W(ACC_W), .N_ACC(N_ACC)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (add_vld),
    .wr_sel    (acc_sel),
    .wr_data   (result),
    .wr_ovf    (guard_ovf),
    .wr_sat    (sat_hit),
    .clr       (clr_sat),
    .acc_q     (acc_q),
    .ovf_q     (ovf_flag),
    .sat_q     (sat_flag),
    .ovf_any_q (ovf_any),
    .sat_any_q (sat_any)
  );

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= add_vld && trap_en && wrap_ovf;
  end
endmodule

// File: rtl/dsat_checker.sv
module dsat_checker #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             add_vld,
  input logic             acc_sel,
  input logic             sat_en,
  input logic             sat_at_31,
  input logic             trap_en,
  input logic [1:0]       clr_sat,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic [1:0]       ovf_flag,
  input logic [1:0]       sat_flag,
  input logic             ovf_any,
  input logic             sat_any,
  input logic             trap_req
);
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (acc0 == '0 && acc1 == '0 && ovf_flag == '0 && sat_flag == '0 && !trap_req));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !add_vld |=> ($stable(acc0) && $stable(acc1)));

  a_r4_narrow_range: assert property (@(posedge clk) disable iff (rst)
    (add_vld && !acc_sel && sat_en && sat_at_31) |=>
      ((&acc0[ACC_W-1:FRAC_W]) || !(|acc0[ACC_W-1:FRAC_W])));

  a_r5_no_ovf0: assert property (@(posedge clk) disable iff (rst)
    (add_vld && !acc_sel && sat_en && sat_at_31) |=> !ovf_flag[0]);

  a_r5_no_ovf1: assert property (@(posedge clk) disable iff (rst)
    (add_vld && acc_sel && sat_en && sat_at_31) |=> !ovf_flag[1]);

  a_r8_sticky0: assert property (@(posedge clk) disable iff (rst)
    (sat_flag[0] && !clr_sat[0]) |=> sat_flag[0]);

  a_r8_sticky1: assert property (@(posedge clk) disable iff (rst)
    (sat_flag[1] && !clr_sat[1]) |=> sat_flag[1]);

  a_r9_trap_cause: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(add_vld && trap_en && !sat_en));

  a_r10_any: assert property (@(posedge clk) disable iff (rst)
    (ovf_any == (|ovf_flag)) && (sat_any == (|sat_flag)));
endmodule

bind dual_acc_sat dsat_checker #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .add_vld(add_vld), .acc_sel(acc_sel),
  .sat_en(sat_en), .sat_at_31(sat_at_31), .trap_en(trap_en),
  .clr_sat(clr_sat), .acc0(acc0), .acc1(acc1), .ovf_flag(ovf_flag),
  .sat_flag(sat_flag), .ovf_any(ovf_any), .sat_any(sat_any),
  .trap_req(trap_req)
);

// File: tb/dual_acc_sat_tb.sv
`timescale 1ns/1ps
module dual_acc_sat_tb;
  localparam int W = 10;
  localparam int G = 3;
  localparam int F = W - G - 1;
  localparam longint MAX40 = (longint'(1) << (W-1)) - 1;
  localparam longint MIN40 = -(longint'(1) << (W-1));
  localparam longint MAX31 = (longint'(1) << F) - 1;
  localparam longint MIN31 = -(longint'(1) << F);

  logic clk = 0;
  logic rst = 1;
  logic add_vld = 0, acc_sel = 0, op_sub = 0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic sat_en = 0, sat_at_31 = 0, trap_en = 0;
  logic [1:0] clr_sat = '0;
  logic [W-1:0] acc0, acc1;
  logic [1:0] ovf_flag, sat_flag;
  logic ovf_any, sat_any, trap_req;

  int total = 0, bad = 0;
  bit done = 0;
  longint ref_acc[2];
  bit ref_ovf[2], ref_sat[2];

  always #4 clk = ~clk;

  dual_acc_sat #(.ACC_W(W), .GUARD_W(G)) u_dut (
    .clk(clk), .rst(rst), .add_vld(add_vld), .acc_sel(acc_sel), .op_sub(op_sub),
    .op_a(op_a), .op_b(op_b), .sat_en(sat_en), .sat_at_31(sat_at_31),
    .trap_en(trap_en), .clr_sat(clr_sat), .acc0(acc0), .acc1(acc1),
    .ovf_flag(ovf_flag), .sat_flag(sat_flag), .ovf_any(ovf_any),
    .sat_any(sat_any), .trap_req(trap_req)
  );

  function automatic longint sx(input logic [W-1:0] v);
    return v[W-1] ? longint'(v) - (longint'(1) << W) : longint'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input longint a, input longint b, input bit sub, input bit sel,
                        input bit en, input bit se, input bit at31, input bit te,
                        input logic [1:0] clr);
    longint s, res;
    bit hit, out40, ovf_new, exp_trap;
    string tag;
    @(negedge clk);
    add_vld = en; acc_sel = sel; op_sub = sub;
    op_a = W'(a); op_b = W'(b);
    sat_en = se; sat_at_31 = at31; trap_en = te; clr_sat = clr;
    s = sx(W'(a)) + (sub ? -sx(W'(b)) : sx(W'(b)));
    out40 = (s > MAX40) || (s < MIN40);
    res = s; hit = 0; tag = "R2";
    if (se && !at31) begin
      if (out40) begin hit = 1; res = (s > 0) ? MAX40 : MIN40; tag = "R3"; end
    end else if (se && at31) begin
      if (s > MAX31) begin hit = 1; res = MAX31; end
      else if (s < MIN31) begin hit = 1; res = MIN31; end
      tag = "R4";
    end else begin
      if (s > MAX40) res = s - (longint'(1) << W);
      if (s < MIN40) res = s + (longint'(1) << W);
      hit = out40; tag = "R6";
    end
    ovf_new = !(se && at31) && ((res > MAX31) || (res < MIN31));
    exp_trap = en && !se && te && out40;
    for (int i = 0; i < 2; i++) ref_sat[i] = ref_sat[i] && !clr[i];
    if (en) begin
      ref_acc[sel] = res;
      ref_ovf[sel] = ovf_new;
      if (hit) ref_sat[sel] = 1;
    end
    @(posedge clk); #1;
    add_vld = 0; clr_sat = '0;
    chk(sx(acc0) == ref_acc[0], (en && !sel) ? tag : "R2", sx(acc0), ref_acc[0]);
    chk(sx(acc1) == ref_acc[1], (en && sel) ? tag : "R2", sx(acc1), ref_acc[1]);
    chk(ovf_flag == {ref_ovf[1], ref_ovf[0]}, (se && at31) ? "R5" : "R7",
        ovf_flag, {ref_ovf[1], ref_ovf[0]});
    chk(sat_flag == {ref_sat[1], ref_sat[0]}, "R8", sat_flag, {ref_sat[1], ref_sat[0]});
    chk(trap_req == exp_trap, "R9", trap_req, exp_trap);
    chk(ovf_any == (ref_ovf[0] | ref_ovf[1]) && sat_any == (ref_sat[0] | ref_sat[1]),
        "R10", {ovf_any, sat_any}, {ref_ovf[0] | ref_ovf[1], ref_sat[0] | ref_sat[1]});
  endtask

  initial begin
    longint bv[10];
    bv[0] = 0; bv[1] = 1; bv[2] = -1; bv[3] = MAX40; bv[4] = MIN40;
    bv[5] = MAX31; bv[6] = MIN31; bv[7] = MAX31 + 1; bv[8] = 37; bv[9] = -100;
    for (int i = 0; i < 2; i++) begin ref_acc[i] = 0; ref_ovf[i] = 0; ref_sat[i] = 0; end
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk(acc0 == '0 && acc1 == '0, "R1", {acc1, acc0}, 0);
    chk(ovf_flag == '0 && sat_flag == '0 && !ovf_any && !sat_any && !trap_req,
        "R1", {ovf_flag, sat_flag, ovf_any, sat_any, trap_req}, 0);
    @(negedge clk); rst = 0;

    // R4: exactly at narrow limits, then one past
    run_op(MAX31, 0, 0, 0, 1, 1, 1, 0, 2'b00);
    run_op(MIN31, 0, 0, 1, 1, 1, 1, 0, 2'b00);
    run_op(MAX31, 1, 0, 0, 1, 1, 1, 0, 2'b00);
    run_op(MIN31, 1, 1, 1, 1, 1, 1, 0, 2'b00);
    // R8: clear of acc0 only, then set-and-clear in one cycle
    run_op(0, 0, 0, 0, 0, 1, 1, 0, 2'b01);
    run_op(MAX40, 1, 0, 0, 1, 0, 0, 1, 2'b01);
    run_op(0, 0, 0, 0, 0, 0, 0, 0, 2'b11);
    // R3: exactly at full limits, then beyond
    run_op(MAX40, 0, 0, 1, 1, 1, 0, 0, 2'b00);
    run_op(MAX40, 1, 0, 1, 1, 1, 0, 0, 2'b00);
    run_op(MIN40, 1, 1, 0, 1, 1, 0, 0, 2'b00);
    // R9: wrap without trap enable gives no request
    run_op(MAX40, 1, 0, 0, 1, 0, 0, 0, 2'b11);

    // Sweep: all op_a patterns against boundary op_b set in every mode (R2..R10)
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int bi = 0; bi < 10; bi++) begin
          run_op(sx(W'(a)), bv[bi], bit'((a + bi) & 1), bit'((a >> 1) & 1),
                 (a + bi) % 11 != 0, m != 0, m == 2, bit'((a >> 2) & 1),
                 {2'((a + bi) % 7 == 0), 2'((a + bi) % 5 == 0)} & 2'b11);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule